// File: doc/BRIEF.md
# Flash Wait-State Read Controller

This block sits between a synchronous CPU read port and a slow on-chip flash array whose read path is combinational but needs time to settle. When the CPU raises a request, the controller accepts the address and drives it to the array. It then keeps the ready line low for a number of extra cycles taken from a 2-bit wait-state register. Once that count has run out it raises ready for one cycle, and in that cycle the array's output is passed to the CPU, which captures it.

The right wait-state value depends on the clock frequency. The array needs no extra cycle below 23 MHz, one cycle from 23 MHz to under 45 MHz, two from 45 MHz to under 68 MHz, and three from 68 MHz to under 90 MHz. Software writes the register at run time. A value below the one the clock needs makes reads shorter, but their data is unreliable. A value taken at acceptance stays in force for the whole access, so a change written during an access only applies to later ones.

Top module: `fws_read_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `cfg_ws` is 0, `cpu_ready` is 0 and `cpu_rdata` is 0 when no request is present.
- R2: A pulse on `cfg_we` stores the 2-bit value on `cfg_wdata`. The stored value appears on `cfg_ws` from the next cycle and stays there until the next write.
- R3: A request is accepted in a cycle where `cpu_req` is high and no access is in progress. With a stored setting N (0 to 3), `cpu_ready` is high exactly N cycles after the acceptance cycle, and low in the cycles between. With N = 0, ready is high in the acceptance cycle itself.
- R4: `cpu_ready` is never high unless a request has been accepted. Each access produces exactly one ready cycle, and the controller is free again in the cycle after it.
- R5: From the cycle after acceptance until the ready cycle, `flash_addr` equals the address that was accepted. Changes on `cpu_addr` during this stall are ignored.
- R6: In the ready cycle, `cpu_rdata` equals `flash_rdata`. In every other cycle it is 0.
- R7: A write to the wait-state register made while an access is in progress does not change the length of that access. The new value applies to the next accepted request.
- R8: A request that is present in the cycle after ready is accepted in that cycle, with no idle cycle in between.
- R9: With the setting at or above the value the clock needs, read data equals the array content at the accepted address. With a lower setting, the sample is taken before the array has settled and is not reliable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the wait-state register |
| cfg_wdata | input | WSW | New wait-state value |
| cfg_ws | output | WSW | Current wait-state value |
| cpu_req | input | 1 | CPU read request |
| cpu_addr | input | AW | CPU read address |
| cpu_ready | output | 1 | High in the cycle in which the CPU captures the data |
| cpu_rdata | output | DW | Read data, valid while `cpu_ready` is high |
| flash_addr | output | AW | Address driven to the flash array |
| flash_rdata | input | DW | Combinational output of the flash array |

## Verification
The assertions assume that reset is applied before the first request. They also assume that `flash_rdata` depends only on `flash_addr`, and that inputs are stable around the rising edge. The stimulus changes all inputs on the falling edge of the clock. It keeps `cpu_req` high until ready appears, and it writes the register only with single-cycle strobes. The flash model in the bench counts how many edges its address has been stable and returns scrambled data before the required two cycles (the value for a 50 MHz clock) have passed. This way, a read taken too early shows up as wrong data.

// File: rtl/fws_pkg.sv
package fws_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } fws_state_e;
endpackage

// File: rtl/fws_cfg_reg.sv
module fws_cfg_reg #(
  parameter int WSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [WSW-1:0] wr_val,
  output logic [WSW-1:0] ws_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q <= '0;
    end else if (wr_en) begin
      ws_q <= wr_val;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ws_q)) else $error("cfg changed without write"); // R7
endmodule

// File: rtl/fws_wait_timer.sv
module fws_wait_timer
  import fws_pkg::*;
#(
  parameter int WSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [WSW-1:0] load_val,
  output logic           busy_o,
  output logic           done_o
);
  localparam logic [WSW-1:0] ONE = WSW'(1);

  fws_state_e     st_q;
  logic [WSW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q  <= ST_WAIT;
            cnt_q <= load_val;
          end
        end
        ST_WAIT: begin
          if (cnt_q == ONE) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: begin
          st_q  <= ST_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign busy_o = (st_q == ST_WAIT);
  assign done_o = busy_o && (cnt_q == ONE);

  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (cnt_q != '0)) else $error("stall with zero count"); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cnt_q > ONE) |=> (busy_o && cnt_q == $past(cnt_q) - ONE))
    else $error("count did not step"); // R3
endmodule

// File: rtl/fws_addr_hold.sv
module fws_addr_hold #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic          hold_sel,
  input  logic [AW-1:0] cpu_addr,
  output logic [AW-1:0] flash_addr
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (capture) begin
      addr_q <= cpu_addr;
    end
  end

  assign flash_addr = hold_sel ? addr_q : cpu_addr;
endmodule

// File: rtl/fws_read_ctrl.sv
module fws_read_ctrl #(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int WSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [WSW-1:0] cfg_wdata,
  output logic [WSW-1:0] cfg_ws,
  input  logic           cpu_req,
  input  logic [AW-1:0]  cpu_addr,
  output logic           cpu_ready,
  output logic [DW-1:0]  cpu_rdata,
  output logic [AW-1:0]  flash_addr,
  input  logic [DW-1:0]  flash_rdata
);
  logic busy;
  logic done;
  logic accept;
  logic zero_ws;

  fws_cfg_reg #(.WSW(WSW)) cfg_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we),
    .wr_val (cfg_wdata),
    .ws_q   (cfg_ws)
  );

  assign accept  = cpu_req && !busy;
  assign zero_ws = (cfg_ws == '0);

  fws_wait_timer #(.WSW(WSW)) tmr_i (
    .clk      (clk),
    .rst      (rst),
    .start    (accept && !zero_ws),
    .load_val (cfg_ws),
    .busy_o   (busy),
    .done_o   (done)
  );

  fws_addr_hold #(.AW(AW)) hold_i (
    .clk        (clk),
    .rst        (rst),
    .capture    (accept),
    .hold_sel   (busy),
    .cpu_addr   (cpu_addr),
    .flash_addr (flash_addr)
  );

  assign cpu_ready = (accept && zero_ws) || done;
  assign cpu_rdata = cpu_ready ? flash_rdata : '0;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cpu_req) |-> !cpu_ready) else $error("ready without request"); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(flash_addr)) else $error("address moved in stall"); // R5
  AST_FREE_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    (busy && cpu_ready) |=> !busy) else $error("access outlived ready"); // R8
endmodule

// File: tb/fws_read_ctrl_tb_top.sv
module fws_read_ctrl_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int WSW = 2;
  localparam int REQ_WS = 2; // needed setting for a 50 MHz clock

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [WSW-1:0] cfg_wdata = '0;
  logic [WSW-1:0] cfg_ws;
  logic cpu_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic [AW-1:0] flash_addr;
  logic [DW-1:0] flash_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int cur_ws = 0;

  always #10 clk = ~clk;

  fws_read_ctrl #(.AW(AW), .DW(DW), .WSW(WSW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_ws(cfg_ws),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .flash_addr(flash_addr), .flash_rdata(flash_rdata)
  );

  function automatic logic [DW-1:0] golden(input logic [AW-1:0] a);
    return (DW'(a) * 32'h9E37_79B1) ^ 32'h3C3C_1234;
  endfunction

  // flash model: output settles only after REQ_WS edges of a stable address
  logic [AW-1:0] fm_last = '0;
  int fm_age = 0;
  int cur_age;
  always_ff @(posedge clk) begin
    if (flash_addr == fm_last) fm_age <= (fm_age < 15) ? fm_age + 1 : fm_age;
    else fm_age <= 1;
    fm_last <= flash_addr;
  end
  always_comb begin
    cur_age = (flash_addr == fm_last) ? fm_age : 0;
    flash_rdata = (cur_age >= REQ_WS) ? golden(flash_addr)
                                      : golden(flash_addr) ^ (32'h5EED_F00D << cur_age);
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ws(input int v);
    @(negedge clk);
    cpu_req = 1'b0;
    cfg_we = 1'b1;
    cfg_wdata = WSW'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    #5;
    chk(cfg_ws == WSW'(v), "R2 stored setting", cfg_ws, v);
    chk(!cpu_ready, "R4 no ready when idle", cpu_ready, 0);
    cur_ws = v;
  endtask

  task automatic idle(input logic [AW-1:0] a);
    @(negedge clk);
    cpu_req = 1'b0;
    cpu_addr = a;
    #5;
    chk(!cpu_ready, "R4 no ready without request", cpu_ready, 0);
    chk(cpu_rdata == '0, "R6 data zero when not ready", cpu_rdata, 0);
  endtask

  task automatic read_op(input logic [AW-1:0] a, input bit wiggle, input int mid_ws,
                         input int exp_ws, output logic [DW-1:0] d);
    int n;
    n = 0;
    @(negedge clk);
    cpu_req = 1'b1;
    cpu_addr = a;
    forever begin
      #5;
      if (n > 0) chk(flash_addr == a, "R5 address held", flash_addr, a);
      if (cpu_ready) break;
      chk(cpu_rdata == '0, "R6 data zero in stall", cpu_rdata, 0);
      if (n > 6) break;
      @(negedge clk);
      n++;
      if (wiggle) cpu_addr = AW'($urandom);
      if (mid_ws >= 0 && n == 1) begin
        cfg_we = 1'b1;
        cfg_wdata = WSW'(mid_ws);
      end else begin
        cfg_we = 1'b0;
      end
    end
    d = cpu_rdata;
    chk(cpu_rdata == flash_rdata, "R6 data passes in ready cycle", cpu_rdata, flash_rdata);
    chk(n == exp_ws, "R3 stall length", n, exp_ws);
    if (mid_ws >= 0) begin
      cfg_we = 1'b0;
      cur_ws = mid_ws;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #5;
    chk(cfg_ws == '0, "R1 reset setting", cfg_ws, 0);
    chk(!cpu_ready, "R1 reset ready", cpu_ready, 0);
    @(negedge clk);
    rst = 1'b0;
    #5;
    chk(cfg_ws == '0, "R1 setting after reset", cfg_ws, 0);
    chk(!cpu_ready, "R1 ready after reset", cpu_ready, 0);
    chk(cpu_rdata == '0, "R1 data after reset", cpu_rdata, 0);

    // single-cycle access below the needed setting: early sample is corrupt
    set_ws(0);
    idle(16'h0100);
    read_op(16'h0101, 1'b0, -1, 0, d);
    chk(d != golden(16'h0101), "R9 early sample unreliable", d, golden(16'h0101));

    // needed setting with address bus wiggling during the stall
    set_ws(2);
    read_op(16'h0202, 1'b1, -1, 2, d);
    chk(d == golden(16'h0202), "R9 data at needed setting", d, golden(16'h0202));

    // setting changed mid-access: current access keeps 3, next uses 0
    set_ws(3);
    idle(16'h0300);
    read_op(16'h0303, 1'b0, 0, 3, d);
    chk(d == golden(16'h0303), "R7 data of long access", d, golden(16'h0303));
    read_op(16'h0304, 1'b0, -1, 0, d);
    chk(cfg_ws == '0, "R7 new setting in force", cfg_ws, 0);

    // back-to-back accesses with no idle cycle
    set_ws(2);
    read_op(16'h0010, 1'b0, -1, 2, d);
    chk(d == golden(16'h0010), "R8 first of pair", d, golden(16'h0010));
    read_op(16'h0011, 1'b0, -1, 2, d);
    chk(d == golden(16'h0011), "R8 second of pair", d, golden(16'h0011));
    set_ws(0);
    read_op(16'h0050, 1'b0, -1, 0, d);
    read_op(16'h0051, 1'b0, -1, 0, d);

    // one wait state still below the need
    set_ws(1);
    idle(16'h0040);
    read_op(16'h0041, 1'b0, -1, 1, d);
    chk(d != golden(16'h0041), "R9 one wait too few", d, golden(16'h0041));

    // constrained random mix
    for (int i = 0; i < 80; i++) begin
      logic [AW-1:0] a;
      if (($urandom % 3) == 0) set_ws(int'($urandom % 4));
      a = AW'($urandom);
      read_op(a, 1'(($urandom % 2)), -1, cur_ws, d);
      if (cur_ws >= REQ_WS)
        chk(d == golden(a), "R9 random read data", d, golden(a));
      if (($urandom % 2) == 0) idle(AW'($urandom));
    end

    idle('0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule